// File: doc/BRIEF.md
# Interrupt Request Sequencer

This block sits between user logic and a link-layer core and decides when an interrupt message must be requested. Two configuration enables choose the signalling scheme: MSI-X when only the MSI-X enable is set, MSI when only the MSI enable is set, and legacy when neither is set. Setting both is illegal. The block then requests nothing and flags the condition. A global interrupt-enable bit gates all generation.

In MSI and legacy modes the user sources are OR-combined into one line. Only a 0-to-1 transition of that line creates an event. The event is held as one pending message request until the link core acknowledges it. Further rising edges that arrive before that acknowledge fold into the same message. In MSI-X mode each vector has a pending bit, set by a per-vector raise pulse. The lowest-numbered pending vector that is not masked is offered to the link core. Its request and vector number stay frozen until the acknowledge. A vector hidden by the function-wide mask or by its own mask bit stays pending and is offered once it is unmasked.

Top module: `irq_requester`

## Requirements
- R1: With `msix_en`=0, `msi_en`=1 selects MSI mode and `msi_en`=0 selects legacy mode. A message raised in these modes carries `evt_is_msi`=1 for MSI and 0 for legacy.
- R2: When `msi_en` and `msix_en` are both 1, `mode_err` is 1 in the same cycle. While this holds, no new `evt_req` or `msix_req` is raised, and source edges and vector raises are discarded. A raise discarded this way is not issued later.
- R3: In MSI or legacy mode, a 0-to-1 transition of the OR of `src` sets `evt_req` one cycle after the clock edge that samples it. A source held high produces no further event.
- R4: `evt_req` stays at 1 until `evt_ack` is sampled at 1 and falls in the next cycle. Rising edges that arrive while it is pending merge into that one message. An edge sampled in the same cycle as the acknowledge starts a new message.
- R5: In MSI-X mode, `vec_raise[i]` sets pending bit i. When no request is outstanding, `msix_req` rises with `msix_vec` set to the lowest pending unmasked index. `msix_req` and `msix_vec` then stay unchanged until `msix_ack` is sampled at 1, even when the masks change.
- R6: No vector is issued while `func_mask` is 1 or while its own `vec_mask` bit is 1. A masked vector keeps its pending bit and is issued after it is unmasked.
- R7: While `irq_enable` is 0, no new request of either kind is raised. Source edges and vector raises are discarded, and any pending MSI or legacy message is dropped.
- R8: After reset, `evt_req`, `evt_is_msi`, `msix_req` and `msix_vec` are 0.
- R9: `msix_req` falls in the cycle after the acknowledge. The pending bit of the served vector is cleared, and the next eligible vector is offered one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_enable | input | 1 | Global interrupt generation enable |
| msi_en | input | 1 | MSI mode enable |
| msix_en | input | 1 | MSI-X mode enable |
| func_mask | input | 1 | Function-wide MSI-X mask |
| vec_mask | input | NUM_VEC | Per-vector MSI-X mask bits |
| src | input | NUM_SRC | User interrupt sources (OR-combined) |
| vec_raise | input | NUM_VEC | Per-vector MSI-X raise pulses |
| evt_ack | input | 1 | Link core accepted the MSI/legacy message |
| msix_ack | input | 1 | Link core sent the MSI-X message |
| evt_req | output | 1 | MSI/legacy message pending |
| evt_is_msi | output | 1 | 1 for MSI message, 0 for legacy |
| msix_req | output | 1 | MSI-X vector request |
| msix_vec | output | $clog2(NUM_VEC) | Vector number of the request |
| mode_err | output | 1 | Both enables set |

## Verification
Two coincidences are driven on purpose. The first is a fresh source rising edge in the same cycle that the MSI message is acknowledged. A new message must follow, not merge into the old one. The second is a change of the mask bits while an MSI-X request is outstanding. The request and vector must hold, and the masking may only affect which vector is offered after the acknowledge. Both cases are judged by a behavioural model that is compared with every output on every clock, together with directed checks on the chosen vector numbers.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY  = 2'd0,
        MODE_MSI     = 2'd1,
        MODE_MSIX    = 2'd2,
        MODE_ILLEGAL = 2'd3
    } irq_mode_e;

    typedef struct packed {
        logic prev;   // previous value of the combined source
        logic pend;   // message waiting for acknowledge
        logic kind;   // 1: MSI, 0: legacy
    } edge_state_t;

    function automatic irq_mode_e decode_mode(input logic msi, input logic msix);
        irq_mode_e m;
        case ({msix, msi})
            2'b00:   m = MODE_LEGACY;
            2'b01:   m = MODE_MSI;
            2'b10:   m = MODE_MSIX;
            default: m = MODE_ILLEGAL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NUM_VEC = 8,
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic [NUM_VEC-1:0] cand,
    output logic               found,
    output logic [VW-1:0]      idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = VW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_edge_merge.sv
module irq_edge_merge
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               is_msi,
    input  logic [NUM_SRC-1:0] src,
    input  logic               ack,
    output logic               req,
    output logic               kind
);
    edge_state_t st_d, st_q;
    logic        line;
    logic        fire;

    always_comb begin
        line      = |src;
        fire      = line & ~st_q.prev;
        st_d      = st_q;
        st_d.prev = line;
        if (!active) begin
            st_d.pend = 1'b0;
        end else begin
            if (fire && (!st_q.pend || ack)) begin
                st_d.kind = is_msi;
            end
            st_d.pend = (st_q.pend && !ack) || fire;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = st_q.pend;
    assign kind = st_q.kind;
endmodule

// File: rtl/irq_msix_ctrl.sv
module irq_msix_ctrl #(
    parameter int NUM_VEC = 8,
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               func_mask,
    input  logic [NUM_VEC-1:0] vec_mask,
    input  logic [NUM_VEC-1:0] raise,
    input  logic               ack,
    output logic               req,
    output logic [VW-1:0]      vec
);
    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic               req;
        logic [VW-1:0]      vec;
    } msix_state_t;

    msix_state_t        st_d, st_q;
    logic [NUM_VEC-1:0] eligible;
    logic [NUM_VEC-1:0] clr;
    logic               have;
    logic [VW-1:0]      pick;

    assign eligible = (active && !func_mask) ? (st_q.pend & ~vec_mask) : '0;

    irq_lowest_pick #(.NUM_VEC(NUM_VEC)) u_pick (
        .cand  (eligible),
        .found (have),
        .idx   (pick)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (st_q.req) begin
            if (ack) begin
                st_d.req         = 1'b0;
                clr[st_q.vec]    = 1'b1;
            end
        end else if (have) begin
            st_d.req = 1'b1;
            st_d.vec = pick;
        end
        st_d.pend = (st_q.pend & ~clr) | (active ? raise : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;
    assign vec = st_q.vec;
endmodule

// File: rtl/irq_requester.sv
module irq_requester
    import irq_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int NUM_SRC = 4,
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_enable,
    input  logic               msi_en,
    input  logic               msix_en,
    input  logic               func_mask,
    input  logic [NUM_VEC-1:0] vec_mask,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_VEC-1:0] vec_raise,
    input  logic               evt_ack,
    input  logic               msix_ack,
    output logic               evt_req,
    output logic               evt_is_msi,
    output logic               msix_req,
    output logic [VW-1:0]      msix_vec,
    output logic               mode_err
);
    irq_mode_e mode;
    logic      edge_active;
    logic      msix_active;

    assign mode        = decode_mode(msi_en, msix_en);
    assign mode_err    = (mode == MODE_ILLEGAL);
    assign edge_active = irq_enable && (mode == MODE_LEGACY || mode == MODE_MSI);
    assign msix_active = irq_enable && (mode == MODE_MSIX);

    irq_edge_merge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (edge_active),
        .is_msi (mode == MODE_MSI),
        .src    (src),
        .ack    (evt_ack),
        .req    (evt_req),
        .kind   (evt_is_msi)
    );

    irq_msix_ctrl #(.NUM_VEC(NUM_VEC)) u_msix (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (msix_active),
        .func_mask (func_mask),
        .vec_mask  (vec_mask),
        .raise     (vec_raise),
        .ack       (msix_ack),
        .req       (msix_req),
        .vec       (msix_vec)
    );
endmodule

// File: rtl/irq_requester_chk.sv
module irq_requester_chk #(
    parameter int NUM_VEC = 8,
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_enable,
    input logic               msi_en,
    input logic               msix_en,
    input logic               func_mask,
    input logic [NUM_VEC-1:0] vec_mask,
    input logic               evt_ack,
    input logic               msix_ack,
    input logic               evt_req,
    input logic               msix_req,
    input logic [VW-1:0]      msix_vec
);
    logic [NUM_VEC-1:0] mask_q;
    logic               fmask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            fmask_q <= 1'b0;
        end else begin
            mask_q  <= vec_mask;
            fmask_q <= func_mask;
        end
    end

    assert_msix_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msix_req && !msix_ack) |=> (msix_req && $stable(msix_vec)));

    assert_msix_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msix_req && msix_ack) |=> !msix_req);

    assert_unmasked_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msix_req) |-> (!fmask_q && !mask_q[msix_vec]));

    assert_evt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_req && !evt_ack && irq_enable && !msix_en) |=> evt_req);

    assert_evt_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_req) |-> $past(!(msi_en && msix_en) && irq_enable));

    assert_msix_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msix_req) |-> $past(irq_enable && msix_en && !msi_en));
endmodule

bind irq_requester irq_requester_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_enable (irq_enable),
    .msi_en     (msi_en),
    .msix_en    (msix_en),
    .func_mask  (func_mask),
    .vec_mask   (vec_mask),
    .evt_ack    (evt_ack),
    .msix_ack   (msix_ack),
    .evt_req    (evt_req),
    .msix_req   (msix_req),
    .msix_vec   (msix_vec)
);

// File: tb/irq_requester_bench.sv
`timescale 1ns/1ps
module irq_requester_bench;
    localparam int NV = 8;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_enable = 1'b0, msi_en = 1'b0, msix_en = 1'b0, func_mask = 1'b0;
    logic [NV-1:0] vec_mask = '0, vec_raise = '0;
    logic [NS-1:0] src = '0;
    logic          evt_ack = 1'b0, msix_ack = 1'b0;
    logic          evt_req, evt_is_msi, msix_req, mode_err;
    logic [2:0]    msix_vec;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string phase = "R8";

    always #2 clk = ~clk;

    irq_requester #(.NUM_VEC(NV), .NUM_SRC(NS)) u_irq_requester (
        .clk(clk), .rst_n(rst_n), .irq_enable(irq_enable), .msi_en(msi_en),
        .msix_en(msix_en), .func_mask(func_mask), .vec_mask(vec_mask), .src(src),
        .vec_raise(vec_raise), .evt_ack(evt_ack), .msix_ack(msix_ack),
        .evt_req(evt_req), .evt_is_msi(evt_is_msi), .msix_req(msix_req),
        .msix_vec(msix_vec), .mode_err(mode_err)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit      m_prev, m_evt, m_kind, m_req;
    bit      m_pend[NV];
    int      m_vec;

    always @(posedge clk) begin
        bit ok, edge_seen, line;
        if (!rst_n) begin
            m_prev = 0; m_evt = 0; m_kind = 0; m_req = 0; m_vec = 0;
            foreach (m_pend[i]) m_pend[i] = 0;
        end else begin
            ok        = irq_enable && !(msi_en && msix_en);
            line      = (src != 0);
            edge_seen = line && !m_prev;
            m_prev    = line;
            if (!ok || msix_en) m_evt = 0;
            else begin
                if (edge_seen && (!m_evt || evt_ack)) m_kind = msi_en;
                m_evt = (m_evt && !evt_ack) || edge_seen;
            end
            if (m_req) begin
                if (msix_ack) begin m_req = 0; m_pend[m_vec] = 0; end
            end else if (ok && msix_en && !func_mask) begin
                for (int i = NV - 1; i >= 0; i--)
                    if (m_pend[i] && !vec_mask[i]) begin m_req = 1; m_vec = i; end
            end
            if (ok && msix_en)
                for (int i = 0; i < NV; i++) if (vec_raise[i]) m_pend[i] = 1;
        end
        #1;
        if (rst_n && !done) begin
            chk(phase, "model evt_req", int'(evt_req), int'(m_evt));
            chk(phase, "model evt_is_msi", int'(evt_is_msi), int'(m_kind));
            chk(phase, "model msix_req", int'(msix_req), int'(m_req));
            chk(phase, "model msix_vec", int'(msix_vec), m_vec);
            chk(phase, "model mode_err", int'(mode_err), int'(msi_en && msix_en));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_evt_ack();
        evt_ack = 1; tick(1); evt_ack = 0;
    endtask

    task automatic pulse_msix_ack();
        msix_ack = 1; tick(1); msix_ack = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        chk("R8", "reset evt_req", int'(evt_req), 0);
        chk("R8", "reset msix_req", int'(msix_req), 0);
        chk("R8", "reset msix_vec", int'(msix_vec), 0);
        rst_n = 1; irq_enable = 1; tick(1);

        // legacy mode
        phase = "R3";
        src = 4'b0010; tick(1);
        chk("R3", "edge raises evt_req", int'(evt_req), 1);
        chk("R1", "legacy kind", int'(evt_is_msi), 0);
        tick(3);
        pulse_evt_ack(); tick(1);
        chk("R3", "held source no new event", int'(evt_req), 0);
        src = 0; tick(1);

        // MSI mode, merging
        phase = "R4";
        msi_en = 1;
        src = 4'b0001; tick(1); src = 0; tick(1); src = 4'b1000; tick(1);
        chk("R1", "msi kind", int'(evt_is_msi), 1);
        pulse_evt_ack(); tick(1);
        chk("R4", "merged into one message", int'(evt_req), 0);
        src = 0; tick(1); src = 1; tick(1);
        src = 0; tick(1);
        src = 1; evt_ack = 1; tick(1); evt_ack = 0;
        chk("R4", "edge with ack starts new message", int'(evt_req), 1);
        pulse_evt_ack(); src = 0; tick(2);

        // illegal mode
        phase = "R2";
        msix_en = 1; tick(1);
        chk("R2", "mode_err", int'(mode_err), 1);
        src = 1; vec_raise = 8'h01; tick(1);
        vec_raise = 0; src = 0; tick(2);
        chk("R2", "no evt in illegal mode", int'(evt_req), 0);
        msi_en = 0; tick(2);
        chk("R2", "raise discarded", int'(msix_req), 0);

        // MSI-X ordering and hold
        phase = "R5";
        vec_raise = 8'h24; tick(1); vec_raise = 0; tick(1);
        chk("R5", "request raised", int'(msix_req), 1);
        chk("R5", "lowest vector first", int'(msix_vec), 2);
        func_mask = 1; vec_mask = 8'h04; tick(3);
        chk("R5", "request held", int'(msix_req), 1);
        chk("R5", "vector held", int'(msix_vec), 2);
        phase = "R9";
        func_mask = 0; vec_mask = 0;
        pulse_msix_ack();
        chk("R9", "drop after ack", int'(msix_req), 0);
        tick(1);
        chk("R9", "next vector", int'(msix_vec), 5);
        pulse_msix_ack(); tick(1);

        // masking
        phase = "R6";
        func_mask = 1; vec_raise = 8'h08; tick(1); vec_raise = 0; tick(3);
        chk("R6", "function mask withholds", int'(msix_req), 0);
        func_mask = 0; tick(1);
        chk("R6", "issued after unmask", int'(msix_vec), 3);
        chk("R6", "issued after unmask req", int'(msix_req), 1);
        pulse_msix_ack();
        vec_mask = 8'h02; vec_raise = 8'h42; tick(1); vec_raise = 0; tick(1);
        chk("R6", "masked vector skipped", int'(msix_vec), 6);
        pulse_msix_ack();
        vec_mask = 0; tick(1);
        chk("R6", "masked vector kept pending", int'(msix_vec), 1);
        pulse_msix_ack(); tick(1);

        // global disable
        phase = "R7";
        irq_enable = 0; vec_raise = 8'h10; src = 1; tick(1);
        vec_raise = 0; tick(2);
        chk("R7", "no msix while disabled", int'(msix_req), 0);
        irq_enable = 1; tick(2);
        chk("R7", "raise while disabled discarded", int'(msix_req), 0);
        msix_en = 0; src = 0; irq_enable = 0; tick(1);
        src = 1; tick(2);
        chk("R7", "no evt while disabled", int'(evt_req), 0);
        tick(2);
        finish_run();
    end
endmodule